// File: doc/BRIEF.md
# Floating-Point Compare Condition-Code Unit

This block compares two IEEE-754 operands and records the outcome as a 2-bit condition code in a 64-bit floating-point status word. A precision select chooses between single precision, taken from the low 32 bits of each operand word, and double precision, which uses the full 64-bit words. A 2-bit field select picks one of four condition-code fields in the status word.

The caller presents the current status word on `fsr_in` together with the operands and pulses `start`. One cycle later the block presents the updated status word on `fsr_o`, pulses `done_o`, and may pulse `trap_o`. Every bit of the status word outside the selected field is copied through unchanged. The one exception is the sticky invalid flag, which is set on an unordered compare when the invalid-trap enable bit is clear.

If either operand is a NaN, the result is unordered. When the invalid-trap enable bit (bit 27 of `fsr_in`) is set, the block requests a floating-point exception trap. When that bit is clear, the block sets the sticky invalid flag (bit 9) instead. In both cases the selected field is written with the unordered code.

Top module: `fcmp_cc_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `fsr_o` is all zeros and `trap_o` and `done_o` are 0.
- R2: For ordered operands, the code written is 2'b01 when A < B, 2'b10 when A > B and 2'b00 when A == B. Code bit 1 goes to the upper bit of the field.
- R3: Field select value 0 writes bits [11:10]. Values 1, 2 and 3 write bits [33:32], [35:34] and [37:36].
- R4: After a compare, every bit of `fsr_o` outside the selected field equals the corresponding bit of `fsr_in` at start. The only exception is bit 9 in the case described by R6.
- R5: If either operand is NaN and `fsr_in[27]` is 1, the field becomes 2'b11, `trap_o` is 1 together with `done_o`, and bit 9 is copied unchanged.
- R6: If either operand is NaN and `fsr_in[27]` is 0, the field becomes 2'b11, bit 9 of `fsr_o` is 1 and `trap_o` stays 0.
- R7: An operand is NaN when its exponent is all ones and its fraction is nonzero. Infinities with a zero fraction are ordered: negative infinity is below every other value and positive infinity is above every other value.
- R8: +0 and -0 compare equal. All other non-NaN values are ordered by sign and then magnitude, with denormals included.
- R9: With `dbl`=0, only bits [31:0] of each operand are used, as single precision, and bits [63:32] have no effect. With `dbl`=1, all 64 bits are used as double precision.
- R10: `done_o` is 1 exactly in the cycle after a cycle with `start`=1. In a cycle after one with `start`=0, `fsr_o` keeps its value whatever the other inputs do.
- R11: `trap_o` is 0 in any cycle that does not follow a start, so a single start gives a trap pulse at most one cycle long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a compare this cycle |
| dbl | input | 1 | 1 = double precision, 0 = single precision |
| fsel | input | 2 | Condition-code field select |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B |
| fsr_in | input | 64 | Status word before the compare |
| fsr_o | output | 64 | Status word after the last compare |
| trap_o | output | 1 | Floating-point exception trap request |
| done_o | output | 1 | Result valid pulse |

## Verification
The hardest cases to reach through random stimulus are the operand pairs that sit on class boundaries. Examples are signed zeros against the smallest denormals, infinities against the largest finite values, and signalling against quiet NaNs. Each of these also has to be seen with the trap enable bit both set and clear, and in every field. The bench sweeps a ranked table of such boundary encodings in both precisions over all operand pairs, all four fields and both trap-enable settings. For single-precision runs, the unused upper operand halves hold a double-precision NaN pattern, so any leakage from those bits changes the result.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
    localparam int DP_W     = 64;
    localparam int DP_EXP   = 11;
    localparam int DP_MAN   = 52;
    localparam int SP_W     = 32;
    localparam int SP_EXP   = 8;
    localparam int SP_MAN   = 23;
    localparam int MAG_W    = DP_W - 1;
    localparam int CC_W     = 2;
    localparam int N_FIELDS = 4;
    localparam int FSEL_W   = $clog2(N_FIELDS);
    localparam int UPPER_GAP = 20;

    typedef enum logic [CC_W-1:0] {
        CC_EQ = 2'b00,
        CC_LT = 2'b01,
        CC_GT = 2'b10,
        CC_UN = 2'b11
    } cc_e;

    typedef struct packed {
        logic             sign;
        logic [MAG_W-1:0] mag;
        logic             nan;
        logic             zero;
    } opnd_t;

    // Field 0 sits at the base; fields 1..3 at base+22, +24, +26.
    function automatic int field_lsb(input int base, input int idx);
        return (idx == 0) ? base : base + UPPER_GAP + CC_W * idx;
    endfunction
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] word_i,
    output opnd_t                info_o
);
    localparam int W = 1 + EXP_W + MAN_W;

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    assign exp_f = word_i[W-2 -: EXP_W];
    assign man_f = word_i[MAN_W-1:0];

    always_comb begin
        info_o.sign = word_i[W-1];
        info_o.mag  = MAG_W'(word_i[W-2:0]);
        info_o.nan  = (&exp_f) && (|man_f);
        info_o.zero = ~|word_i[W-2:0];
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
(
    input  opnd_t a_i,
    input  opnd_t b_i,
    output cc_e   cc_o
);
    logic mag_lt;
    logic mag_eq;

    assign mag_lt = a_i.mag < b_i.mag;
    assign mag_eq = a_i.mag == b_i.mag;

    always_comb begin
        if (a_i.nan || b_i.nan) begin
            cc_o = CC_UN;
        end else if (a_i.zero && b_i.zero) begin
            cc_o = CC_EQ;
        end else if (a_i.sign != b_i.sign) begin
            cc_o = a_i.sign ? CC_LT : CC_GT;
        end else if (mag_eq) begin
            cc_o = CC_EQ;
        end else if (a_i.sign) begin
            cc_o = mag_lt ? CC_GT : CC_LT;
        end else begin
            cc_o = mag_lt ? CC_LT : CC_GT;
        end
    end
endmodule

// File: rtl/fcmp_field_update.sv
module fcmp_field_update
    import fcmp_pkg::*;
#(
    parameter int FSR_W    = 64,
    parameter int BASE_LSB = 10,
    parameter int MASK_BIT = 27,
    parameter int ACC_BIT  = 9
) (
    input  logic [FSR_W-1:0]  fsr_i,
    input  logic [FSEL_W-1:0] sel_i,
    input  cc_e               cc_i,
    output logic [FSR_W-1:0]  fsr_o,
    output logic              trap_o
);
    logic [CC_W-1:0]  cc_bits;
    logic [FSR_W-1:0] clr_m [N_FIELDS];
    logic [FSR_W-1:0] set_m [N_FIELDS];
    logic             unord;

    assign cc_bits = cc_i;
    assign unord   = (cc_i == CC_UN);

    for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
        localparam int LSB = field_lsb(BASE_LSB, f);
        logic hit;
        assign hit      = (sel_i == FSEL_W'(f));
        assign clr_m[f] = hit ? (FSR_W'({CC_W{1'b1}}) << LSB) : '0;
        assign set_m[f] = hit ? (FSR_W'(cc_bits) << LSB) : '0;
    end

    always_comb begin
        logic [FSR_W-1:0] clr_all;
        logic [FSR_W-1:0] set_all;
        clr_all = '0;
        set_all = '0;
        for (int f = 0; f < N_FIELDS; f++) begin
            clr_all = clr_all | clr_m[f];
            set_all = set_all | set_m[f];
        end
        fsr_o  = (fsr_i & ~clr_all) | set_all;
        trap_o = unord && fsr_i[MASK_BIT];
        if (unord && !fsr_i[MASK_BIT]) begin
            fsr_o[ACC_BIT] = 1'b1;
        end
    end
endmodule

// File: rtl/fcmp_cc_unit.sv
module fcmp_cc_unit
    import fcmp_pkg::*;
#(
    parameter int FSR_W    = 64,
    parameter int CC_BASE  = 10,
    parameter int MASK_BIT = 27,
    parameter int ACC_BIT  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dbl,
    input  logic [FSEL_W-1:0] fsel,
    input  logic [DP_W-1:0]   op_a,
    input  logic [DP_W-1:0]   op_b,
    input  logic [FSR_W-1:0]  fsr_in,
    output logic [FSR_W-1:0]  fsr_o,
    output logic              trap_o,
    output logic              done_o
);
    typedef struct packed {
        logic [FSR_W-1:0] fsr;
        logic             trap;
        logic             done;
    } regs_t;

    regs_t            r_d, r_q;
    logic [DP_W-1:0]  ops   [2];
    opnd_t            sp_c  [2];
    opnd_t            dp_c  [2];
    opnd_t            sel_c [2];
    cc_e              cc;
    logic [FSR_W-1:0] fsr_nxt;
    logic             trap_req;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar k = 0; k < 2; k++) begin : g_opnd
        fcmp_classify #(.EXP_W(SP_EXP), .MAN_W(SP_MAN)) u_sp (
            .word_i (ops[k][SP_W-1:0]),
            .info_o (sp_c[k])
        );
        fcmp_classify #(.EXP_W(DP_EXP), .MAN_W(DP_MAN)) u_dp (
            .word_i (ops[k]),
            .info_o (dp_c[k])
        );
        assign sel_c[k] = dbl ? dp_c[k] : sp_c[k];
    end

    fcmp_order u_order (
        .a_i  (sel_c[0]),
        .b_i  (sel_c[1]),
        .cc_o (cc)
    );

    fcmp_field_update #(
        .FSR_W    (FSR_W),
        .BASE_LSB (CC_BASE),
        .MASK_BIT (MASK_BIT),
        .ACC_BIT  (ACC_BIT)
    ) u_update (
        .fsr_i  (fsr_in),
        .sel_i  (fsel),
        .cc_i   (cc),
        .fsr_o  (fsr_nxt),
        .trap_o (trap_req)
    );

    always_comb begin
        r_d      = r_q;
        r_d.trap = 1'b0;
        r_d.done = start;
        if (start) begin
            r_d.fsr  = fsr_nxt;
            r_d.trap = trap_req;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign fsr_o  = r_q.fsr;
    assign trap_o = r_q.trap;
    assign done_o = r_q.done;

    function automatic logic [CC_W-1:0] pick_field(input logic [FSR_W-1:0] v,
                                                   input logic [FSEL_W-1:0] s);
        int lsb;
        lsb = field_lsb(CC_BASE, int'(s));
        return v[lsb +: CC_W];
    endfunction

    AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done_o); // R10
    AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(start)); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(fsr_o)); // R10
    AST_TRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !trap_o); // R11
    AST_TRAP_HAS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> fsr_o[MASK_BIT]); // R5
    AST_TRAP_FIELD_UN: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (pick_field(fsr_o, $past(fsel)) == 2'b11)); // R5
    AST_TRAP_NO_ACCRUE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (fsr_o[ACC_BIT] == $past(fsr_in[ACC_BIT]))); // R5
    AST_ACC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!$past(fsr_in[ACC_BIT]) || fsr_o[ACC_BIT])); // R6
    AST_KEEP_MASK_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (fsr_o[MASK_BIT] == $past(fsr_in[MASK_BIT]))); // R4
endmodule

// File: tb/fcmp_cc_unit_tb.sv
module fcmp_cc_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dbl = 1'b0;
    logic [1:0]  fsel = 2'd0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [63:0] fsr_in = '0;
    logic [63:0] fsr_o;
    logic        trap_o;
    logic        done_o;

    int total = 0;
    int bad = 0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #(CLK_PERIOD/2) clk = ~clk;

    fcmp_cc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .dbl(dbl), .fsel(fsel),
        .op_a(op_a), .op_b(op_b), .fsr_in(fsr_in),
        .fsr_o(fsr_o), .trap_o(trap_o), .done_o(done_o)
    );

    // Values in ascending order; rank -1 marks NaN; both zeros share rank 4.
    logic [31:0] sp_v [NV] = '{
        32'hff800000, 32'hc0000000, 32'hbf800000, 32'h80000001, 32'h80000000,
        32'h00000000, 32'h00000001, 32'h3f800000, 32'h3fc00000, 32'h7f7fffff,
        32'h7f800000, 32'h7fc00000, 32'h7f800001, 32'hffc00000};
    logic [63:0] dp_v [NV] = '{
        64'hfff0000000000000, 64'hc000000000000000, 64'hbff0000000000000,
        64'h8000000000000001, 64'h8000000000000000, 64'h0000000000000000,
        64'h0000000000000001, 64'h3ff0000000000000, 64'h3ff8000000000000,
        64'h7fefffffffffffff, 64'h7ff0000000000000, 64'h7ff8000000000000,
        64'h7ff0000000000001, 64'hfff8000000000000};
    int rank [NV] = '{0, 1, 2, 3, 4, 4, 5, 6, 7, 8, 9, -1, -1, -1};

    function automatic logic [63:0] next_rand(input logic [63:0] s);
        logic [63:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 7);
        x = x ^ (x << 17);
        return x;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_cmp(input bit d, input int ia, input int ib, input int fs, input bit mk);
        logic [63:0] base, exp_fsr, fmask;
        logic [1:0]  code;
        bit          un, exp_trap;
        int          pos;
        string       tag;
        rng  = next_rand(rng);
        base = rng;
        base[27] = mk;
        un   = (rank[ia] < 0) || (rank[ib] < 0);
        if (un)                    code = 2'b11;
        else if (rank[ia] < rank[ib]) code = 2'b01;
        else if (rank[ia] > rank[ib]) code = 2'b10;
        else                       code = 2'b00;
        pos   = (fs == 0) ? 10 : 30 + 2 * fs;
        fmask = 64'd3 << pos;
        exp_fsr = (base & ~fmask) | (64'(code) << pos);
        exp_trap = un && mk;
        if (un && !mk) exp_fsr[9] = 1'b1;
        if (un) tag = mk ? "R5" : "R6";
        else if (rank[ia] == 4 && rank[ib] == 4) tag = "R8";
        else if (rank[ia] == 0 || rank[ia] == 9 || rank[ib] == 0 || rank[ib] == 9) tag = "R7";
        else tag = d ? "R2" : "R9";

        @(negedge clk);
        dbl    = d;
        fsel   = 2'(fs);
        op_a   = d ? dp_v[ia] : {32'h7ff80000, sp_v[ia]};
        op_b   = d ? dp_v[ib] : {32'hfff00001, sp_v[ib]};
        fsr_in = base;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        chk({tag, "/R3 field"}, 64'(fsr_o[pos +: 2]), 64'(code));
        chk("R4 other bits", fsr_o & ~fmask, exp_fsr & ~fmask);
        chk(mk ? "R5 trap" : "R6 trap", 64'(trap_o), 64'(exp_trap));
        chk("R10 done", 64'(done_o), 64'd1);
        fsr_in = ~base;
        op_a   = op_b;
        @(negedge clk);
        chk("R10 hold", fsr_o, exp_fsr);
        chk("R10 done low", 64'(done_o), 64'd0);
        chk("R11 trap low", 64'(trap_o), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset fsr", fsr_o, 64'd0);
        chk("R1 reset trap", 64'(trap_o), 64'd0);
        chk("R1 reset done", 64'(done_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {fsr_o[61:0], trap_o, done_o}, 64'd0);

        for (int d = 0; d < 2; d++)
            for (int ia = 0; ia < NV; ia++)
                for (int ib = 0; ib < NV; ib++)
                    for (int fs = 0; fs < 4; fs++)
                        for (int mk = 0; mk < 2; mk++)
                            run_cmp(d[0], ia, ib, fs, mk[0]);

        // Back-to-back: unordered with trap enabled, then an ordered compare.
        @(negedge clk);
        dbl = 1'b1; fsel = 2'd3; op_a = dp_v[11]; op_b = dp_v[0];
        fsr_in = 64'h0000_0000_0800_0000; start = 1'b1;
        @(negedge clk);
        chk("R5 b2b trap", 64'(trap_o), 64'd1);
        chk("R3 b2b field3", 64'(fsr_o[37:36]), 64'd3);
        fsel = 2'd1; op_a = dp_v[1]; op_b = dp_v[8]; fsr_in = 64'h0000_0000_0800_0000;
        @(negedge clk);
        start = 1'b0;
        chk("R11 b2b trap drop", 64'(trap_o), 64'd0);
        chk("R3 b2b field1", 64'(fsr_o[33:32]), 64'd1);
        chk("R10 b2b done", 64'(done_o), 64'd1);
        @(negedge clk);
        chk("R10 b2b done drop", 64'(done_o), 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R10 actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule